// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who drives a shared external memory bus: the local bus controller or an outside master. The outside master asks for the bus with a hold request. The arbiter never cuts short a local access that is already running. It waits for that access to end, then floats the address, data, strobe and chip-select lines, with the chip selects pulled high by resistors. After that it raises a hold acknowledge. While the outside master owns the bus, the arbiter can raise a bus-request output to show that the local side has an external access waiting. Only the outside master dropping its hold request gives the bus back. The request output does not.

Giving the bus back takes a fixed number of cycles. During that time the acknowledge is already low but the local controller still has no grant. The grant comes back only when the sequence is over, so the first local cycle after a hold starts on lines that are driven again. A mode enable lets the arbiter ignore hold requests completely.

Top module: `xbus_hold_arb`

## Requirements
- R1: During and after a synchronous reset, `ext_ack_o`, `ext_breq_o` and `bus_float_o` are 0 and `lcl_grant_o` is 1.
- R2: `ext_hold_i` passes through `SYNC_STAGES` (default 2) flops before use. With the local side idle, a hold request applied between clock edges shows `ext_ack_o`=1 after the third following edge and not after the second.
- R3: If `lcl_busy_i` is 1 when the hold request is seen, `lcl_grant_o` drops to 0 and `ext_ack_o` stays 0 until `lcl_busy_i` is 0. The acknowledge then rises one edge later.
- R4: While the bus is handed over, `ext_ack_o`=1, `bus_float_o`=1 (lines undriven, chip selects high via pull-ups) and `lcl_grant_o`=0.
- R5: `ext_breq_o` equals `lcl_pend_i` while `ext_ack_o` is 1, and it is 0 at all other times.
- R6: Regain starts only when the synchronised hold request is 0, on the third edge after `ext_hold_i` falls. A 1 on `ext_breq_o` does not start it.
- R7: The regain phase lasts `REGAIN_CYCLES` (default 2) cycles, with `ext_ack_o`=0, `ext_breq_o`=0, `bus_float_o`=1 and `lcl_grant_o`=0.
- R8: Dropping the hold request while `ext_breq_o` is 0 regains the bus through the same sequence as R6 and R7.
- R9: `lcl_grant_o` returns to 1, and `bus_float_o` to 0, only on the edge that ends the regain phase.
- R10: While `arb_en_i` is 0 and the local side owns the bus, `ext_hold_i` has no effect on any output.
- R11: If the hold request is withdrawn while the arbiter is still waiting for a busy cycle, it returns to local ownership without ever asserting `ext_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_en_i | input | 1 | Mode enable; 0 makes the arbiter ignore hold requests |
| ext_hold_i | input | 1 | Hold request from the outside master, asynchronous, active high |
| lcl_busy_i | input | 1 | Local bus controller has a cycle in progress |
| lcl_pend_i | input | 1 | Local bus controller has an external access waiting |
| ext_ack_o | output | 1 | Hold acknowledge to the outside master |
| ext_breq_o | output | 1 | Request to get the bus back |
| bus_float_o | output | 1 | Float address, data, strobes and chip selects |
| lcl_grant_o | output | 1 | Local controller may start a bus cycle |

## Verification
A wrong internal state always shows at the ports, because every state has its own output pattern. Local ownership gives grant only. The wait for a busy cycle gives all outputs low. The handed-over state gives acknowledge and float. Regain gives float only. A transition that is lost or taken too early therefore shows up on the next edge as the wrong mix of grant, float and acknowledge. The bench checks each step at the exact edge count that synchronisation and the regain counter predict, so an off-by-one in either one is caught within one cycle.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

    typedef enum logic [1:0] {
        ST_OWN       = 2'd0,
        ST_RELEASING = 2'd1,
        ST_RELEASED  = 2'd2,
        ST_REGAIN    = 2'd3
    } xbh_state_e;

    typedef struct packed {
        logic ack;
        logic breq;
        logic flt;
        logic grant;
    } xbh_out_t;

    function automatic xbh_out_t xbh_decode(xbh_state_e st, logic pend);
        xbh_out_t o;
        o = '0;
        unique case (st)
            ST_OWN:       o.grant = 1'b1;
            ST_RELEASING: o = '0;
            ST_RELEASED: begin
                o.ack  = 1'b1;
                o.flt  = 1'b1;
                o.breq = pend;
            end
            ST_REGAIN:    o.flt = 1'b1;
            default:      o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else if (i == 0) chain_q[i] <= d_i;
                else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbh_fsm.sv
module xbh_fsm
    import xbh_pkg::*;
#(
    parameter int REGAIN_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_s_i,
    input  logic       en_i,
    input  logic       busy_i,
    output xbh_state_e state_o
);
    localparam int CW = (REGAIN_CYCLES > 1) ? $clog2(REGAIN_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(REGAIN_CYCLES - 1);

    xbh_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic hold_req;

    assign hold_req = hold_s_i & en_i;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_OWN: begin
                if (hold_req) st_d = busy_i ? ST_RELEASING : ST_RELEASED;
            end
            ST_RELEASING: begin
                if (!hold_req)   st_d = ST_OWN;
                else if (!busy_i) st_d = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (!hold_s_i) begin
                    st_d  = ST_REGAIN;
                    cnt_d = '0;
                end
            end
            ST_REGAIN: begin
                if (cnt_q == CNT_LAST) st_d = ST_OWN;
                else cnt_d = cnt_q + 1'b1;
            end
            default: st_d = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_OWN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state_o = st_q;

    // R3
    release_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RELEASED && $past(st_q) != ST_RELEASED) |-> !$past(busy_i));

    // R6
    regain_needs_hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REGAIN && $past(st_q) == ST_RELEASED) |-> !$past(hold_s_i));

    // R10
    disabled_stays_own_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OWN && !en_i) |=> st_q == ST_OWN);
endmodule

// File: rtl/xbh_outdec.sv
module xbh_outdec
    import xbh_pkg::*;
(
    input  xbh_state_e state_i,
    input  logic       pend_i,
    output xbh_out_t   out_o
);
    assign out_o = xbh_decode(state_i, pend_i);
endmodule

// File: rtl/xbus_hold_arb.sv
module xbus_hold_arb
    import xbh_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int REGAIN_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_en_i,
    input  logic ext_hold_i,
    input  logic lcl_busy_i,
    input  logic lcl_pend_i,
    output logic ext_ack_o,
    output logic ext_breq_o,
    output logic bus_float_o,
    output logic lcl_grant_o
);
    logic       hold_s;
    xbh_state_e state;
    xbh_out_t   outs;

    xbh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(ext_hold_i), .q_o(hold_s)
    );

    xbh_fsm #(.REGAIN_CYCLES(REGAIN_CYCLES)) u_fsm (
        .clk(clk), .rst(rst), .hold_s_i(hold_s), .en_i(arb_en_i),
        .busy_i(lcl_busy_i), .state_o(state)
    );

    xbh_outdec u_dec (.state_i(state), .pend_i(lcl_pend_i), .out_o(outs));

    assign ext_ack_o   = outs.ack;
    assign ext_breq_o  = outs.breq;
    assign bus_float_o = outs.flt;
    assign lcl_grant_o = outs.grant;

    // R5
    breq_only_when_acked_chk: assert property (@(posedge clk) disable iff (rst)
        ext_breq_o |-> ext_ack_o);

    // R4
    grant_never_with_float_chk: assert property (@(posedge clk) disable iff (rst)
        lcl_grant_o |-> (!bus_float_o && !ext_ack_o));

    // R9
    grant_after_regain_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lcl_grant_o) |-> ($past(bus_float_o) && !$past(ext_ack_o)) || $past(!ext_ack_o && !bus_float_o));

    // R7
    ack_fall_keeps_float_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_ack_o) |-> (bus_float_o && !lcl_grant_o));
endmodule

// File: tb/xbus_hold_arb_tb_top.sv
module xbus_hold_arb_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arb_en_i = 1'b0, ext_hold_i = 1'b0, lcl_busy_i = 1'b0, lcl_pend_i = 1'b0;
    logic ext_ack_o, ext_breq_o, bus_float_o, lcl_grant_o;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xbus_hold_arb dut_i (
        .clk(clk), .rst(rst), .arb_en_i(arb_en_i), .ext_hold_i(ext_hold_i),
        .lcl_busy_i(lcl_busy_i), .lcl_pend_i(lcl_pend_i), .ext_ack_o(ext_ack_o),
        .ext_breq_o(ext_breq_o), .bus_float_o(bus_float_o), .lcl_grant_o(lcl_grant_o)
    );

    // {hold, en, busy, pend, wait[3:0], ack, breq, float, grant}
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        12'b0100_0001_0001, // R1 idle owner
        12'b1000_0100_0001, // R10 hold ignored while disabled
        12'b1110_0011_0000, // R3 busy: grant withdrawn, no ack
        12'b1111_0010_0000, // R5 pending but not handed over: no breq
        12'b1101_0001_1110, // R3 R4 R5 busy ends: handed over, breq follows pend
        12'b1100_0001_1010, // R5 pend low
        12'b1101_0001_1110, // R5 pend high again
        12'b0101_0010_1110, // R6 hold dropped, still released for two edges
        12'b0101_0001_0010, // R7 regain cycle one
        12'b0101_0001_0010, // R7 regain cycle two
        12'b0101_0001_0001, // R9 grant back at end of regain
        12'b1100_0010_0001, // R2 not yet after two edges
        12'b1100_0001_1010, // R2 R4 handed over on third edge
        12'b0100_0011_0010, // R8 regain without breq
        12'b0100_0010_0001, // R8 R9 owner again
        12'b1110_0011_0000, // R3 waiting on busy
        12'b0110_0011_0001, // R11 withdrawn while waiting
        12'b0100_0001_0001  // R11 never acknowledged
    };

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {ext_ack_o, ext_breq_o, bus_float_o, lcl_grant_o};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ack,breq,float,grant} actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 4'b0001);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", 4'b0001);

        for (int i = 0; i < NV; i++) begin
            {ext_hold_i, arb_en_i, lcl_busy_i, lcl_pend_i} = VEC[i][11:8];
            repeat (int'(VEC[i][7:4])) @(posedge clk);
            #1;
            check($sformatf("table vector %0d", i), VEC[i][3:0]);
        end

        // R1 reset while the bus is handed over
        ext_hold_i = 1'b1; lcl_pend_i = 1'b1;
        repeat (3) @(posedge clk); #1;
        check("R4 handed over before reset", 4'b1110);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset from handed over", 4'b0001);
        ext_hold_i = 1'b0; lcl_pend_i = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;

        // R6 breq high does not start regain while hold stays high
        ext_hold_i = 1'b1;
        repeat (3) @(posedge clk); #1;
        lcl_pend_i = 1'b1;
        repeat (6) @(posedge clk); #1;
        check("R6 breq alone keeps bus handed over", 4'b1110);

        // R10 clearing enable does not end a handed-over phase while hold is high
        arb_en_i = 1'b0;
        repeat (2) @(posedge clk); #1;
        check("R10 enable cleared while released", 4'b1110);
        ext_hold_i = 1'b0; arb_en_i = 1'b1; lcl_pend_i = 1'b0;
        repeat (5) @(posedge clk); #1;
        check("R9 final owner", 4'b0001);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule